// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog for a platform controller. It sits on a small register bus with byte-lane strobes. Software programs a 10-bit timeout, counted in ticks of an external tick-enable input (one tick is 0.6 s, so 1023 ticks is about 613 s). It clears the halt bit to start the countdown and writes the kick register to restart it.

Expiry happens in two stages. The first time the count runs out, the block sets a status flag, pulses an event output for one clock, and starts a second countdown of the same length. If that second countdown also runs out with no kick in between, the block raises a sticky reset request. The request is blocked if the no-reboot control bit or the no-reboot strap input is set. The status flags stay write-one-to-clear throughout. A boot-status flag records that the reset now ending was caused by the watchdog, as reported on an input.

Top module: `dual_expiry_wdog`

## Requirements
- R1: After reset the timeout register reads 0x03FF, the count reads 1023, the control register reads 0x0001 (halted, no-reboot clear), the status register reads 0, and both the event and reset-request outputs are low.
- R2: Register index 0 holds the timeout in bits [9:0] and six spare bits in [15:10]. A write changes only the bytes whose strobe is set (strobe bit 0 covers bits [7:0], strobe bit 1 covers bits [15:8]), and reads return all 16 stored bits.
- R3: Whenever the counter is loaded, a timeout field below MIN_TICKS (default 4) is raised to MIN_TICKS. The count is therefore never zero.
- R4: Any write to register index 1 loads the counter with the clamped timeout. The written data is ignored. Reading index 1 returns the current count in bits [9:0].
- R5: Control register index 2, bit 0, is the halt bit. While it is set, ticks leave the count unchanged. Once it is cleared, each tick decrements the count from where it stopped.
- R6: A tick that arrives when the count is 1 and no earlier expiry is pending is a first expiry. It sets status bit 0, pulses the event output high for exactly one clock, and reloads the clamped timeout.
- R7: A tick that arrives when the count is 1 and an earlier expiry is pending is a second expiry. It sets status bit 1, reloads the counter and raises the reset-request output.
- R8: Once raised, the reset-request output stays high until the block's reset input is asserted.
- R9: A kick clears the pending-expiry state, so the next expiry counts as a first expiry again.
- R10: If control bit 1 (no-reboot) or the no-reboot strap input is high when a second expiry occurs, the reset request is not raised, but status bit 1 is still set.
- R11: Writing 1 to a bit of status register index 3 (with strobe bit 0 set) clears that flag and leaves the others unchanged. A flag that is set in the same cycle as it is cleared stays set.
- R12: Status bit 2 takes the value of the boot-cause input at the first clock after reset is released, and it is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | One-cycle countdown tick enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register index |
| bus_be_i | input | 2 | Byte-lane write enables |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| noreboot_strap_i | input | 1 | Strap that blocks the reset request |
| boot_cause_i | input | 1 | High when the previous reset came from the watchdog |
| wdog_evt_o | output | 1 | One-clock pulse on a first expiry |
| wdog_rst_req_o | output | 1 | Sticky system reset request |

## Verification
Read data follows the address in the same cycle. A register write or a tick that is present at a clock edge shows up in the read data, the status and the count just after that edge. The event pulse and the reset request both appear after the same edge as the expiring tick, and the event falls one clock later. The boot-status flag appears after the first edge following reset release.

The bench drives inputs on the falling edge and samples 5 ns later, which is 5 ns before the next rising edge. Its reference model advances on each rising edge, so every comparison sees settled values for exactly one edge's worth of change. Directed checks count ticks edge by edge and insert an idle cycle before changing the strap, so that the last tick of a run is not counted against the wrong setting.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_TMO  = 2'd0,
    REG_KICK = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } wdog_reg_e;

  localparam int CTRL_HALT_BIT = 0;
  localparam int CTRL_NR_BIT   = 1;

  localparam int STS_FIRST  = 0;
  localparam int STS_SECOND = 1;
  localparam int STS_BOOT   = 2;
  localparam int STS_W      = 3;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMO_W  = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     tmo_raw_o,
  output logic                  halt_o,
  output logic                  nr_o,
  output logic                  kick_o,
  output logic [STS_W-1:0]      sts_clr_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] TMO_RST = DATA_W'({TMO_W{1'b1}});

  logic [DATA_W-1:0] tmo_q, tmo_d, lane_mask;
  logic              halt_q, halt_d, nr_q, nr_d;
  logic              tmo_we, ctrl_we, stat_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_i[g]}};
  end

  assign tmo_we  = wr_i && (addr_i == REG_TMO);
  assign ctrl_we = wr_i && (addr_i == REG_CTRL) && be_i[0];
  assign stat_we = wr_i && (addr_i == REG_STAT) && be_i[0];

  always_comb begin
    tmo_d  = tmo_q;
    halt_d = halt_q;
    nr_d   = nr_q;
    if (tmo_we) begin
      tmo_d = (tmo_q & ~lane_mask) | (wdata_i & lane_mask);
    end
    if (ctrl_we) begin
      halt_d = wdata_i[CTRL_HALT_BIT];
      nr_d   = wdata_i[CTRL_NR_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= TMO_RST;
      halt_q <= 1'b1;
      nr_q   <= 1'b0;
    end else begin
      tmo_q  <= tmo_d;
      halt_q <= halt_d;
      nr_q   <= nr_d;
    end
  end

  assign tmo_raw_o = tmo_q;
  assign halt_o    = halt_q;
  assign nr_o      = nr_q;
  assign kick_o    = wr_i && (addr_i == REG_KICK);
  assign sts_clr_o = stat_we ? wdata_i[STS_W-1:0] : '0;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TMO_W     = 10,
  parameter int MIN_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             kick_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic [TMO_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] MIN_L = TMO_W'(MIN_TICKS);
  localparam logic [TMO_W-1:0] ONE_L = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q, cnt_d, load_val;
  logic             run;

  assign load_val = (tmo_i < MIN_L) ? MIN_L : tmo_i;
  assign run      = tick_i && !halt_i;
  assign expire_o = run && !kick_i && (cnt_q <= ONE_L);

  always_comb begin
    cnt_d = cnt_q;
    if (kick_i || expire_o) begin
      cnt_d = load_val;
    end else if (run) begin
      cnt_d = cnt_q - ONE_L;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  input  logic             kick_i,
  input  logic             nr_block_i,
  input  logic [STS_W-1:0] sts_clr_i,
  input  logic             boot_cause_i,
  output logic [STS_W-1:0] sts_o,
  output logic             evt_o,
  output logic             rst_req_o
);
  logic             pend_q, pend_d;
  logic             init_q;
  logic [STS_W-1:0] sts_q, sts_d;
  logic             evt_q, evt_d, rst_q, rst_d;
  logic             first_exp, second_exp;

  assign first_exp  = expire_i && !pend_q;
  assign second_exp = expire_i && pend_q;

  always_comb begin
    pend_d = pend_q;
    if (kick_i) begin
      pend_d = 1'b0;
    end else if (expire_i) begin
      pend_d = 1'b1;
    end

    sts_d = sts_q & ~sts_clr_i;
    if (first_exp) begin
      sts_d[STS_FIRST] = 1'b1;
    end
    if (second_exp) begin
      sts_d[STS_SECOND] = 1'b1;
    end
    if (!init_q) begin
      sts_d[STS_BOOT] = boot_cause_i;
    end

    evt_d = first_exp;
    rst_d = rst_q || (second_exp && !nr_block_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      init_q <= 1'b0;
      sts_q  <= '0;
      evt_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      init_q <= 1'b1;
      sts_q  <= sts_d;
      evt_q  <= evt_d;
      rst_q  <= rst_d;
    end
  end

  assign sts_o     = sts_q;
  assign evt_o     = evt_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog
  import wdog_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TMO_W     = 10,
  parameter int MIN_TICKS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_en_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W/8-1:0] bus_be_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                noreboot_strap_i,
  input  logic                boot_cause_i,
  output logic                wdog_evt_o,
  output logic                wdog_rst_req_o
);
  logic [DATA_W-1:0] tmo_raw;
  logic              halt, nr_ctrl, kick, expire, nr_block;
  logic [STS_W-1:0]  sts_clr, sts;
  logic [TMO_W-1:0]  cnt;

  wdog_regfile #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .be_i      (bus_be_i),
    .wdata_i   (bus_wdata_i),
    .tmo_raw_o (tmo_raw),
    .halt_o    (halt),
    .nr_o      (nr_ctrl),
    .kick_o    (kick),
    .sts_clr_o (sts_clr)
  );

  wdog_counter #(.TMO_W(TMO_W), .MIN_TICKS(MIN_TICKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_en_i),
    .halt_i   (halt),
    .kick_i   (kick),
    .tmo_i    (tmo_raw[TMO_W-1:0]),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  assign nr_block = nr_ctrl || noreboot_strap_i;

  wdog_stage u_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .kick_i       (kick),
    .nr_block_i   (nr_block),
    .sts_clr_i    (sts_clr),
    .boot_cause_i (boot_cause_i),
    .sts_o        (sts),
    .evt_o        (wdog_evt_o),
    .rst_req_o    (wdog_rst_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (wdog_reg_e'(bus_addr_i))
      REG_TMO:  bus_rdata_o = tmo_raw;
      REG_KICK: bus_rdata_o[TMO_W-1:0] = cnt;
      REG_CTRL: begin
        bus_rdata_o[CTRL_HALT_BIT] = halt;
        bus_rdata_o[CTRL_NR_BIT]   = nr_ctrl;
      end
      REG_STAT: bus_rdata_o[STS_W-1:0] = sts;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int TMO_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             kick,
  input logic             nr_eff,
  input logic [TMO_W-1:0] cnt,
  input logic [STS_W-1:0] sts,
  input logic             evt,
  input logic             rst_req
);
  a_r3_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  a_r5_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !kick) |=> $stable(cnt));

  a_r6_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  a_r7_rst_with_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> sts[STS_SECOND]);

  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  a_r10_noreboot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_eff && !rst_req) |=> !rst_req);
endmodule

bind dual_expiry_wdog wdog_checker #(.TMO_W(TMO_W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .halt    (halt),
  .kick    (kick),
  .nr_eff  (nr_block),
  .cnt     (cnt),
  .sts     (sts),
  .evt     (wdog_evt_o),
  .rst_req (wdog_rst_req_o)
);

// File: tb/dual_expiry_wdog_tb.sv
module dual_expiry_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n, tick, wr, strap, boot;
  logic [1:0]  addr, be;
  logic [15:0] wdata, rdata;
  logic        evt, rstq;
  int          total = 0, bad = 0, n_evt = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  dual_expiry_wdog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .noreboot_strap_i(strap), .boot_cause_i(boot),
    .wdog_evt_o(evt), .wdog_rst_req_o(rstq)
  );

  // behavioural reference model
  logic [15:0] m_tmo;
  bit m_halt, m_nr, m_pend, m_s1, m_s2, m_sb, m_evt, m_rst, m_init;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmo = 16'h03FF; m_halt = 1; m_nr = 0; m_pend = 0; m_cnt = 1023;
      m_s1 = 0; m_s2 = 0; m_sb = 0; m_evt = 0; m_rst = 0; m_init = 0;
    end else begin
      bit kk, ex, oh, on, op; int ld;
      kk = wr && addr == 2'd1;
      ld = (m_tmo[9:0] < 4) ? 4 : int'(m_tmo[9:0]);
      oh = m_halt; on = m_nr; op = m_pend;
      ex = tick && !oh && !kk && m_cnt <= 1;
      if (wr && addr == 2'd0) begin
        if (be[0]) m_tmo[7:0]  = wdata[7:0];
        if (be[1]) m_tmo[15:8] = wdata[15:8];
      end
      if (wr && addr == 2'd2 && be[0]) begin m_halt = wdata[0]; m_nr = wdata[1]; end
      if (wr && addr == 2'd3 && be[0]) begin
        if (wdata[0]) m_s1 = 0;
        if (wdata[1]) m_s2 = 0;
        if (wdata[2]) m_sb = 0;
      end
      if (!m_init) begin m_sb = boot; m_init = 1; end
      m_evt = ex && !op;
      if (ex && !op) m_s1 = 1;
      if (ex && op) begin m_s2 = 1; if (!(on || strap)) m_rst = 1; end
      if (kk) m_pend = 0; else if (ex) m_pend = 1;
      if (kk || ex) m_cnt = ld;
      else if (tick && !oh) m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // model comparison every clock, 5 ns before the rising edge
  always @(negedge clk) begin
    if (evt === 1'b1) n_evt++;
    #5;
    if (rst_n && !done) begin
      logic [15:0] e;
      string t;
      case (addr)
        2'd0: begin e = m_tmo; t = "R2 model tmo"; end
        2'd1: begin e = 16'(m_cnt); t = "R4 model count"; end
        2'd2: begin e = {14'd0, m_nr, m_halt}; t = "R5 model ctrl"; end
        default: begin e = {13'd0, m_sb, m_s2, m_s1}; t = "R11 model status"; end
      endcase
      chk(t, 32'(rdata), 32'(e));
      chk("R6 model event", 32'(evt), 32'(m_evt));
      chk("R7 model reset request", 32'(rstq), 32'(m_rst));
    end
  end

  task automatic cyc(int n, bit t);
    repeat (n) begin @(negedge clk); wr = 0; tick = t; end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk); wr = 1; addr = a; wdata = d; be = b; tick = 0;
    @(negedge clk); wr = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); wr = 0; tick = 0; addr = a;
    #5 v = rdata;
  endtask

  task automatic do_reset(bit b);
    @(negedge clk); rst_n = 0; boot = b;
    cyc(3, 0);
    rst_n = 1;
    cyc(2, 0);
    boot = 0;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int e0;
    rst_n = 0; tick = 0; wr = 0; addr = 0; be = 0; wdata = 0; strap = 0; boot = 0;
    do_reset(0);
    // R1 reset state
    peek(0, v); chk("R1 tmo reset", 32'(v), 32'h03FF);
    peek(1, v); chk("R1 count reset", 32'(v), 32'd1023);
    peek(2, v); chk("R1 ctrl reset", 32'(v), 32'h0001);
    peek(3, v); chk("R1 status reset", 32'(v), 32'h0000);
    chk("R1 outputs low", 32'({evt, rstq}), 32'd0);
    // R2 byte lanes
    wr_reg(0, 16'hA800, 2'b10); peek(0, v); chk("R2 high lane", 32'(v), 32'hA8FF);
    wr_reg(0, 16'h0005, 2'b01); peek(0, v); chk("R2 low lane", 32'(v), 32'hA805);
    // R3 clamp, R4 kick data ignored
    wr_reg(0, 16'hA801, 2'b01); wr_reg(1, 16'h1234, 2'b11);
    peek(1, v); chk("R3 clamp to min", 32'(v), 32'd4);
    cyc(5, 1); peek(1, v); chk("R5 halted ticks", 32'(v), 32'd4);
    wr_reg(0, 16'hA80A, 2'b01); wr_reg(1, 16'hFFFF, 2'b01);
    peek(1, v); chk("R4 kick loads timeout", 32'(v), 32'd10);
    // R5 halt/resume
    wr_reg(2, 16'h0000, 2'b01); cyc(3, 1);
    peek(1, v); chk("R5 counting", 32'(v), 32'd7);
    wr_reg(2, 16'h0001, 2'b01); cyc(4, 1);
    peek(1, v); chk("R5 freeze", 32'(v), 32'd7);
    wr_reg(2, 16'h0000, 2'b01);
    // R6 first expiry
    e0 = n_evt;
    cyc(7, 1); peek(3, v);
    chk("R6 first flag", 32'(v), 32'h1);
    chk("R6 one event pulse", 32'(n_evt - e0), 32'd1);
    chk("R6 no reset yet", 32'(rstq), 32'd0);
    peek(1, v); chk("R6 reload after first", 32'(v), 32'd10);
    // R7 second expiry, R8 sticky
    cyc(10, 1); peek(3, v);
    chk("R7 second flag", 32'(v), 32'h3);
    chk("R7 reset request", 32'(rstq), 32'd1);
    cyc(20, 1); peek(3, v); chk("R8 still requesting", 32'(rstq), 32'd1);
    // R11 W1C
    wr_reg(3, 16'h0001, 2'b01); peek(3, v); chk("R11 clear first only", 32'(v), 32'h2);
    // R8 cleared by reset, R12 boot flag
    do_reset(1);
    chk("R8 reset clears request", 32'(rstq), 32'd0);
    peek(3, v); chk("R12 boot flag", 32'(v), 32'h4);
    wr_reg(3, 16'h0004, 2'b01); peek(3, v); chk("R12 boot clear", 32'(v), 32'h0);
    // R9 kick clears pending
    wr_reg(0, 16'h0006, 2'b11); wr_reg(2, 16'h0000, 2'b01); wr_reg(1, 16'h0000, 2'b11);
    cyc(6, 1); peek(3, v); chk("R9 first again", 32'(v), 32'h1);
    wr_reg(1, 16'h0000, 2'b11);
    e0 = n_evt;
    cyc(6, 1); peek(3, v);
    chk("R9 still first", 32'(v), 32'h1);
    chk("R9 event again", 32'(n_evt - e0), 32'd1);
    chk("R9 no reset", 32'(rstq), 32'd0);
    // R10 no-reboot control bit
    wr_reg(2, 16'h0002, 2'b01);
    cyc(6, 1); peek(3, v);
    chk("R10 ctrl second flag", 32'(v), 32'h3);
    chk("R10 ctrl blocks reset", 32'(rstq), 32'd0);
    // R10 strap
    wr_reg(2, 16'h0000, 2'b01); wr_reg(3, 16'h0007, 2'b01);
    strap = 1; wr_reg(1, 16'h0000, 2'b11);
    cyc(12, 1); cyc(1, 0); peek(3, v);
    chk("R10 strap second flag", 32'(v), 32'h3);
    chk("R10 strap blocks reset", 32'(rstq), 32'd0);
    strap = 0;
    cyc(6, 1); peek(3, v);
    chk("R7 reset once unblocked", 32'(rstq), 32'd1);
    cyc(2, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule